// File: doc/BRIEF.md
# Global Nucleotide Alignment Engine

This block aligns two short nucleotide strings end to end. Each string holds up to `MAX_LEN` symbols of 2 bits (A=0, C=1, G=2, T=3). Symbol k sits at bits `[2k+1:2k]`, and symbol 0 comes first. A start pulse latches both strings, their lengths and three signed scores: match, mismatch and gap. The engine then fills a score grid one cell per clock. Rows follow string A and columns follow string B. For every cell it keeps a 2-bit record of which neighbour gave the best value.

After the fill, the engine walks the recorded choices back from the far corner to the origin. It emits one alignment operation per clock, from the last column of the alignment back to the first. It counts these operations to give the alignment length. A serial divider then forms a fixed-point score per aligned column. A one-cycle `done` pulse marks the point where the score, the length and the normalised score are all valid.

Top module: `nw_align_engine`

## Requirements
- R1: After reset, `busy`, `done` and `op_valid` are 0.
- R2: `final_score` equals the best global alignment score. Cell (i,j) takes the maximum of three candidates: diagonal + (match or mismatch score), cell above + gap, and cell to the left + gap.
- R3: Row 0 and column 0 hold pure gap paths, with values j·gap and i·gap. When one string is empty, the operation stream is only gaps.
- R4: When candidates tie, the diagonal wins first, then the cell above, then the cell to the left.
- R5: The traceback emits operations on consecutive clocks, in reverse order, while `op_valid` is 1. The codes are: 0 = matching symbols, 1 = substituted symbols, 2 = a symbol of A against a gap, 3 = a symbol of B against a gap.
- R6: `aln_len` equals the number of operations emitted. It lies between max(len_a, len_b) and len_a + len_b.
- R7: `norm_score` equals the score times 2^FRAC divided by `aln_len`, truncated toward zero. It is 0 when `aln_len` is 0.
- R8: `done` is a single-cycle pulse. `busy` is high from the cycle after start until `done`. A start pulse while busy is ignored.
- R9: The three scores are sampled at start, so different settings change the result for the same strings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an alignment (used only when idle) |
| seq_a | input | 2*MAX_LEN | String A, symbol 0 in the low bits |
| len_a | input | IW | Symbols in A |
| seq_b | input | 2*MAX_LEN | String B |
| len_b | input | IW | Symbols in B |
| match_score | input | SCW | Signed match reward |
| mismatch_score | input | SCW | Signed mismatch score |
| gap_score | input | SCW | Signed gap score |
| busy | output | 1 | Alignment in progress |
| done | output | 1 | Results valid pulse |
| final_score | output | SW | Signed global score |
| aln_len | output | LW | Number of alignment operations |
| norm_score | output | SW+FRAC | Signed fixed-point score per column |
| op_valid | output | 1 | Operation code valid |
| op_code | output | 2 | Alignment operation |

## Verification
A wrong cell value or choice record inside the grid reaches the ports only after the whole fill. It appears as a wrong `final_score` at `done`, or as a different operation stream that starts one clock after the fill ends. A traceback fault shows up as a code that does not fit the strings, a gap in the `op_valid` run, or a length count that is off. A divider fault is visible only in `norm_score`, about NW clocks after the last operation. For this reason, every test compares the full operation stream and all three results against an independent model of the grid.

// File: rtl/nw_pkg.sv
package nw_pkg;
    typedef enum logic [1:0] {
        MV_STOP = 2'd0,
        MV_DIAG = 2'd1,
        MV_UP   = 2'd2,
        MV_LEFT = 2'd3
    } move_t;

    typedef enum logic [1:0] {
        OP_MATCH = 2'd0,
        OP_SUBST = 2'd1,
        OP_A_GAP = 2'd2,
        OP_B_GAP = 2'd3
    } op_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FILL  = 2'd1,
        ST_TRACE = 2'd2,
        ST_DIV   = 2'd3
    } state_t;

    typedef struct packed {
        logic [7:0] dummy_unused;
    } pad_t;
endpackage

// File: rtl/nw_cell_pick.sv
module nw_cell_pick
    import nw_pkg::*;
#(
    parameter int SW  = 15,
    parameter int SCW = 8
) (
    input  logic signed [SW-1:0]  diag_in,
    input  logic signed [SW-1:0]  up_in,
    input  logic signed [SW-1:0]  left_in,
    input  logic                  same_sym,
    input  logic signed [SCW-1:0] match_sc,
    input  logic signed [SCW-1:0] mis_sc,
    input  logic signed [SCW-1:0] gap_sc,
    output logic signed [SW-1:0]  best,
    output move_t                 best_mv
);
    logic signed [SW-1:0] cand_d, cand_u, cand_l;

    always_comb begin
        cand_d = diag_in + SW'(same_sym ? match_sc : mis_sc);
        cand_u = up_in + SW'(gap_sc);
        cand_l = left_in + SW'(gap_sc);
        if (cand_d >= cand_u && cand_d >= cand_l) begin
            best = cand_d; best_mv = MV_DIAG;
        end else if (cand_u >= cand_l) begin
            best = cand_u; best_mv = MV_UP;
        end else begin
            best = cand_l; best_mv = MV_LEFT;
        end
    end
endmodule

// File: rtl/nw_serial_div.sv
module nw_serial_div #(
    parameter int NW = 23,
    parameter int DW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic [NW-1:0] num,
    input  logic [DW-1:0] den,
    output logic          fin,
    output logic [NW-1:0] quot
);
    localparam int CW = $clog2(NW + 1);
    logic [DW:0]   rem;
    logic [DW:0]   rem_sh;
    logic [NW-1:0] qsh;
    logic [CW-1:0] cnt;
    logic          run;

    assign rem_sh = {rem[DW-1:0], qsh[NW-1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            rem <= '0; qsh <= '0; cnt <= '0; run <= 1'b0; fin <= 1'b0; quot <= '0;
        end else begin
            fin <= 1'b0;
            if (go) begin
                rem <= '0; qsh <= num; cnt <= CW'(NW); run <= 1'b1;
            end else if (run) begin
                if (rem_sh >= {1'b0, den}) begin
                    rem <= rem_sh - {1'b0, den};
                    qsh <= {qsh[NW-2:0], 1'b1};
                end else begin
                    rem <= rem_sh;
                    qsh <= {qsh[NW-2:0], 1'b0};
                end
                cnt <= cnt - 1'b1;
                if (cnt == CW'(1)) begin
                    run  <= 1'b0;
                    fin  <= 1'b1;
                    quot <= (rem_sh >= {1'b0, den}) ? {qsh[NW-2:0], 1'b1} : {qsh[NW-2:0], 1'b0};
                end
            end
        end
    end

    // R7: the remainder left after division is always below the divisor
    assert_rem_below_den_R7: assert property (@(posedge clk) disable iff (rst)
        (fin && den != '0) |-> (rem < {1'b0, den}));
endmodule

// File: rtl/nw_align_engine.sv
module nw_align_engine
    import nw_pkg::*;
#(
    parameter int MAX_LEN = 16,
    parameter int SCW     = 8,
    parameter int FRAC    = 8,
    localparam int IW     = $clog2(MAX_LEN + 1),
    localparam int SW     = SCW + $clog2(2 * MAX_LEN) + 2,
    localparam int LW     = $clog2(2 * MAX_LEN + 1),
    localparam int NW     = SW + FRAC
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [2*MAX_LEN-1:0]  seq_a,
    input  logic [IW-1:0]         len_a,
    input  logic [2*MAX_LEN-1:0]  seq_b,
    input  logic [IW-1:0]         len_b,
    input  logic signed [SCW-1:0] match_score,
    input  logic signed [SCW-1:0] mismatch_score,
    input  logic signed [SCW-1:0] gap_score,
    output logic                  busy,
    output logic                  done,
    output logic signed [SW-1:0]  final_score,
    output logic [LW-1:0]         aln_len,
    output logic signed [NW-1:0]  norm_score,
    output logic                  op_valid,
    output logic [1:0]            op_code
);
    localparam int ROW   = MAX_LEN + 1;
    localparam int CELLS = ROW * ROW;
    localparam int CW    = $clog2(CELLS);

    function automatic logic [CW-1:0] cell_at(input logic [IW-1:0] r, input logic [IW-1:0] c);
        return CW'(r) * CW'(ROW) + CW'(c);
    endfunction

    state_t st;
    logic [2*MAX_LEN-1:0]  ra, rb;
    logic [IW-1:0]         rla, rlb, ri, rj;
    logic signed [SCW-1:0] cm, cx, cg;
    logic signed [SW-1:0]  sc_mem [CELLS];
    move_t                 mv_mem [CELLS];

    logic [IW-1:0]        im1, jm1;
    logic                 sym_eq;
    logic signed [SW-1:0] pick_sc, cell_sc;
    move_t                pick_mv, cell_mv, tr_mv;

    assign im1    = (ri == '0) ? '0 : ri - 1'b1;
    assign jm1    = (rj == '0) ? '0 : rj - 1'b1;
    assign sym_eq = ra[2*im1 +: 2] == rb[2*jm1 +: 2];
    assign tr_mv  = mv_mem[cell_at(ri, rj)];

    nw_cell_pick #(.SW(SW), .SCW(SCW)) u_pick (
        .diag_in (sc_mem[cell_at(im1, jm1)]),
        .up_in   (sc_mem[cell_at(im1, rj)]),
        .left_in (sc_mem[cell_at(ri, jm1)]),
        .same_sym(sym_eq),
        .match_sc(cm), .mis_sc(cx), .gap_sc(cg),
        .best    (pick_sc),
        .best_mv (pick_mv)
    );

    always_comb begin
        if (ri == '0 && rj == '0) begin
            cell_sc = '0; cell_mv = MV_STOP;
        end else if (ri == '0) begin
            cell_sc = sc_mem[cell_at(ri, jm1)] + SW'(cg); cell_mv = MV_LEFT;
        end else if (rj == '0) begin
            cell_sc = sc_mem[cell_at(im1, rj)] + SW'(cg); cell_mv = MV_UP;
        end else begin
            cell_sc = pick_sc; cell_mv = pick_mv;
        end
    end

    logic          div_go, div_fin;
    logic [NW-1:0] div_num, div_q;
    logic [SW-1:0] score_mag;

    assign score_mag = final_score[SW-1] ? SW'(-final_score) : SW'(final_score);
    assign div_num   = NW'(score_mag) << FRAC;

    nw_serial_div #(.NW(NW), .DW(LW)) u_div (
        .clk(clk), .rst(rst), .go(div_go), .num(div_num), .den(aln_len),
        .fin(div_fin), .quot(div_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= ST_IDLE; busy <= 1'b0; done <= 1'b0; op_valid <= 1'b0; op_code <= '0;
            final_score <= '0; aln_len <= '0; norm_score <= '0; div_go <= 1'b0;
            ra <= '0; rb <= '0; rla <= '0; rlb <= '0; ri <= '0; rj <= '0;
            cm <= '0; cx <= '0; cg <= '0;
        end else begin
            done     <= 1'b0;
            op_valid <= 1'b0;
            div_go   <= 1'b0;
            unique case (st)
                ST_IDLE: if (start) begin
                    ra <= seq_a; rb <= seq_b;
                    rla <= (len_a > IW'(MAX_LEN)) ? IW'(MAX_LEN) : len_a;
                    rlb <= (len_b > IW'(MAX_LEN)) ? IW'(MAX_LEN) : len_b;
                    cm <= match_score; cx <= mismatch_score; cg <= gap_score;
                    ri <= '0; rj <= '0; busy <= 1'b1; st <= ST_FILL;
                end
                ST_FILL: begin
                    sc_mem[cell_at(ri, rj)] <= cell_sc;
                    mv_mem[cell_at(ri, rj)] <= cell_mv;
                    if (rj == rlb) begin
                        rj <= '0;
                        if (ri == rla) begin
                            final_score <= cell_sc;
                            ri <= rla; rj <= rlb; aln_len <= '0;
                            st <= ST_TRACE;
                        end else begin
                            ri <= ri + 1'b1;
                        end
                    end else begin
                        rj <= rj + 1'b1;
                    end
                end
                ST_TRACE: begin
                    if (tr_mv == MV_STOP) begin
                        if (aln_len == '0) begin
                            norm_score <= '0; done <= 1'b1; busy <= 1'b0; st <= ST_IDLE;
                        end else begin
                            div_go <= 1'b1; st <= ST_DIV;
                        end
                    end else begin
                        op_valid <= 1'b1;
                        aln_len  <= aln_len + 1'b1;
                        unique case (tr_mv)
                            MV_DIAG: begin
                                op_code <= sym_eq ? OP_MATCH : OP_SUBST;
                                ri <= im1; rj <= jm1;
                            end
                            MV_UP:   begin op_code <= OP_A_GAP; ri <= im1; end
                            default: begin op_code <= OP_B_GAP; rj <= jm1; end
                        endcase
                    end
                end
                ST_DIV: if (div_fin) begin
                    norm_score <= final_score[SW-1] ? -$signed(div_q) : $signed(div_q);
                    done <= 1'b1; busy <= 1'b0; st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R5: operations appear only during an active alignment
    assert_op_in_busy_R5: assert property (@(posedge clk) disable iff (rst)
        op_valid |-> busy);
    // R8: done lasts one cycle and coincides with the end of busy
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
    // R3: stored choices along row 0 point left during traceback
    assert_row0_left_R3: assert property (@(posedge clk) disable iff (rst)
        (st == ST_TRACE && ri == '0 && rj != '0) |-> (tr_mv == MV_LEFT));
    // R6: reported length lies between the longer string and the sum
    assert_len_bounds_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> ({1'b0, aln_len} <= (LW+1)'(rla) + (LW+1)'(rlb) &&
                  aln_len >= LW'(rla) && aln_len >= LW'(rlb)));
endmodule

// File: tb/nw_align_engine_test.sv
module nw_align_engine_test;
    localparam int ML = 16;
    localparam int FR = 8;
    logic clk = 0, rst = 1, start = 0;
    logic [2*ML-1:0] seq_a = '0, seq_b = '0;
    logic [4:0] len_a = '0, len_b = '0;
    logic signed [7:0] m_sc = 0, x_sc = 0, g_sc = 0;
    logic busy, done, op_valid;
    logic signed [14:0] final_score;
    logic [5:0] aln_len;
    logic signed [22:0] norm_score;
    logic [1:0] op_code;

    int checks = 0, errors = 0;
    int got_ops[64];
    int n_got = 0;
    bit collecting = 0, seen = 0, gapped = 0, broken = 0;

    always #5 clk = ~clk;

    nw_align_engine uut (
        .clk(clk), .rst(rst), .start(start), .seq_a(seq_a), .len_a(len_a),
        .seq_b(seq_b), .len_b(len_b), .match_score(m_sc), .mismatch_score(x_sc),
        .gap_score(g_sc), .busy(busy), .done(done), .final_score(final_score),
        .aln_len(aln_len), .norm_score(norm_score), .op_valid(op_valid), .op_code(op_code)
    );

    always @(negedge clk) if (collecting) begin
        if (op_valid) begin
            if (gapped) broken = 1;
            if (n_got < 64) got_ops[n_got] = int'(op_code);
            n_got++; seen = 1;
        end else if (seen) gapped = 1;
    end

    function automatic int sym(string s, int k);
        case (s[k])
            "A": return 0; "C": return 1; "G": return 2; default: return 3;
        endcase
    endfunction

    function automatic logic [2*ML-1:0] pack(string s);
        logic [2*ML-1:0] v = '0;
        for (int k = 0; k < s.len(); k++) v[2*k +: 2] = 2'(sym(s, k));
        return v;
    endfunction

    task automatic check(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic run_case(string req, string sa, string sb, int mt, int mm, int gp, bit poke);
        int s[17][17];
        int mv[17][17];
        int eops[64];
        int ne = 0, i, j, la, lb, cyc, en;
        la = sa.len(); lb = sb.len();
        for (int r = 0; r <= la; r++)
            for (int c = 0; c <= lb; c++) begin
                if (r == 0 && c == 0) begin s[r][c] = 0; mv[r][c] = 0; end
                else if (r == 0) begin s[r][c] = c * gp; mv[r][c] = 3; end
                else if (c == 0) begin s[r][c] = r * gp; mv[r][c] = 2; end
                else begin
                    int d, u, l;
                    d = s[r-1][c-1] + ((sym(sa, r-1) == sym(sb, c-1)) ? mt : mm);
                    u = s[r-1][c] + gp; l = s[r][c-1] + gp;
                    if (d >= u && d >= l) begin s[r][c] = d; mv[r][c] = 1; end
                    else if (u >= l) begin s[r][c] = u; mv[r][c] = 2; end
                    else begin s[r][c] = l; mv[r][c] = 3; end
                end
            end
        i = la; j = lb;
        while (mv[i][j] != 0) begin
            if (mv[i][j] == 1) begin
                eops[ne] = (sym(sa, i-1) == sym(sb, j-1)) ? 0 : 1; i--; j--;
            end else if (mv[i][j] == 2) begin eops[ne] = 2; i--; end
            else begin eops[ne] = 3; j--; end
            ne++;
        end
        en = (ne == 0) ? 0 : ((s[la][lb] < 0) ? -(((-s[la][lb]) * (1 << FR)) / ne)
                                              : ((s[la][lb] * (1 << FR)) / ne));
        @(negedge clk);
        seq_a = pack(sa); seq_b = pack(sb); len_a = 5'(la); len_b = 5'(lb);
        m_sc = 8'(mt); x_sc = 8'(mm); g_sc = 8'(gp);
        n_got = 0; seen = 0; gapped = 0; broken = 0; collecting = 1;
        start = 1;
        @(negedge clk); start = 0;
        check("R8", "busy after start", busy, 1);
        cyc = 0;
        while (!done && cyc < 5000) begin
            if (poke && cyc == 3) begin
                start = 1; seq_a = pack("TTTT"); len_a = 4; m_sc = 9; g_sc = -9;
            end else start = 0;
            @(negedge clk); cyc++;
        end
        start = 0; collecting = 0;
        check("R8", {req, " done seen"}, done, 1);
        check("R2", {req, " final score"}, final_score, s[la][lb]);
        check("R6", {req, " length"}, aln_len, ne);
        check("R6", {req, " op count"}, n_got, ne);
        check("R7", {req, " normalised"}, norm_score, en);
        check("R5", {req, " contiguous ops"}, broken, 0);
        for (int k = 0; k < ne && k < n_got; k++)
            if (got_ops[k] != eops[k]) begin
                check("R5", {req, " op code"}, got_ops[k], eops[k]);
                break;
            end
        @(negedge clk);
        check("R8", {req, " done single cycle"}, done, 0);
        check("R8", {req, " idle after"}, busy, 0);
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "busy at reset", busy, 0);
        check("R1", "done at reset", done, 0);
        check("R1", "op_valid at reset", op_valid, 0);
        rst = 0;
        @(negedge clk);
        run_case("R2", "ACGTACGT", "ACGTACGT", 2, -1, -2, 0);
        run_case("R2", "GATTACA", "GCATGCT", 1, -1, -1, 0);
        run_case("R3", "", "ACG", 1, -1, -2, 0);
        run_case("R3", "TTGA", "", 1, -1, -3, 0);
        run_case("R7", "", "", 1, -1, -1, 0);
        run_case("R4", "A", "C", 1, -2, -1, 0);
        run_case("R4", "AC", "CA", 0, -2, -1, 0);
        run_case("R9", "GATTACA", "GCATGCT", 5, -3, -4, 0);
        run_case("R8", "ACGGT", "AGT", 2, -1, -1, 1);
        run_case("R7", "TTTTTTTT", "AAAA", 1, -3, -2, 0);
        run_case("R2", "ACGTTGCAACGTTGCA", "TGCAACGTACGGTGCA", 3, -2, -3, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule